// File: doc/BRIEF.md
# Seven-Segment Display Register Bank

This block holds the values shown on four seven-segment digits. A processor writes to it through one port. When the write strobe is high at a rising clock edge, the data byte goes into the slot that the index selects. Each slot keeps its byte until a later write to the same index overwrites it. Between writes the bank behaves like a register file that software can only write, and its outputs stay valid the whole time.

Each slot feeds its own decoder. The decoder turns the stored byte into a 7-bit pattern, with 1 meaning a lit segment. Byte values 0x00 to 0x0F show the matching hex digit. The value 0xFF switches the digit off. Every other byte shows a question-mark glyph. The bank refreshes no digits itself and has no decimal points.

Top module: `seg_disp_bank`

## Requirements
- R1: While reset is high at a rising edge, every slot is loaded with 0xFF. Every digit reads blank (all segment bits 0) from the first sample after that edge.
- R2: With `wr_en` high at a rising edge and `wr_idx` below 4, `wr_data` is stored in slot `wr_idx`. The new glyph appears on `seg_o[wr_idx]` right after that edge.
- R3: A write leaves every slot other than the addressed one unchanged.
- R4: With `wr_en` low, all four outputs hold their values, whatever `wr_idx` and `wr_data` carry.
- R5: A write whose index is 4 or more changes no slot.
- R6: Segment bit 0 is a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f, bit 6 g. Stored values 0x0 to 0xF give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F, 0x77, 0x7C, 0x39, 0x5E, 0x79 and 0x71 in that order.
- R7: A stored value of 0xFF gives the pattern 0x00.
- R8: Any stored value from 0x10 to 0xFE gives the question-mark pattern 0x53 (segments a, b, e, g).
- R9: When writes to the same slot come on consecutive edges, the later one wins. Each write takes effect at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst | input | 1 | Synchronous reset, active high; blanks all slots |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W (3) | Slot index; 4 or more is ignored |
| wr_data | input | 8 | Byte to store |
| seg_o | output | NUM_SLOTS x 7 (28) | Segment pattern per slot, slot k at bits [7k+6:7k] |

## Verification
A corrupted slot register stays visible on its output until that slot is written again. A faulty write decode shows up one clock after the stray write: the wrong digit changes, or a digit stays unchanged when it should change. After every write the bench compares all four digits with a model of the bank, so such an error is caught at the next sample. The decoder is checked on all sixteen hex values, on the blank code, and on values at both edges of the question-mark range.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

    localparam int DATA_W = 8;
    localparam int SEG_W  = 7;

    typedef logic [DATA_W-1:0] disp_byte_t;
    typedef logic [SEG_W-1:0]  seg_pat_t;

    // Kind of glyph that a stored byte maps to
    typedef enum logic [1:0] {
        GK_HEX   = 2'd0,
        GK_BLANK = 2'd1,
        GK_QUERY = 2'd2
    } glyph_kind_e;

    // Decoder datapath word: kind plus the nibble that a hex glyph needs
    typedef struct packed {
        glyph_kind_e kind;
        logic [3:0]  nib;
    } glyph_sel_t;

    localparam disp_byte_t BLANK_CODE = 8'hFF;
    localparam seg_pat_t   PAT_BLANK  = 7'h00;
    localparam seg_pat_t   PAT_QUERY  = 7'h53;

    function automatic glyph_sel_t classify(input disp_byte_t v);
        glyph_sel_t s;
        s.nib = v[3:0];
        if (v == BLANK_CODE)
            s.kind = GK_BLANK;
        else if (v[7:4] == 4'h0)
            s.kind = GK_HEX;
        else
            s.kind = GK_QUERY;
        return s;
    endfunction

    // Segment order {g,f,e,d,c,b,a}
    function automatic seg_pat_t hex_glyph(input logic [3:0] n);
        seg_pat_t p;
        case (n)
            4'h0: p = 7'h3F;
            4'h1: p = 7'h06;
            4'h2: p = 7'h5B;
            4'h3: p = 7'h4F;
            4'h4: p = 7'h66;
            4'h5: p = 7'h6D;
            4'h6: p = 7'h7D;
            4'h7: p = 7'h07;
            4'h8: p = 7'h7F;
            4'h9: p = 7'h6F;
            4'hA: p = 7'h77;
            4'hB: p = 7'h7C;
            4'hC: p = 7'h39;
            4'hD: p = 7'h5E;
            4'hE: p = 7'h79;
            default: p = 7'h71;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seg_wr_demux.sv
module seg_wr_demux #(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    output logic [NUM_SLOTS-1:0] slot_we
);

    // Full-width compare: indices past the last slot select nothing
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_sel
        assign slot_we[k] = wr_en && (wr_idx == IDX_W'(k));
    end

endmodule

// File: rtl/seg_slot_reg.sv
module seg_slot_reg
    import seg_disp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  disp_byte_t din,
    output disp_byte_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= BLANK_CODE;
        else if (we)
            q <= din;
    end

endmodule

// File: rtl/seg_glyph_dec.sv
module seg_glyph_dec
    import seg_disp_pkg::*;
(
    input  disp_byte_t val,
    output seg_pat_t   pat
);

    glyph_sel_t sel;

    always_comb begin
        sel = classify(val);
        case (sel.kind)
            GK_HEX:   pat = hex_glyph(sel.nib);
            GK_BLANK: pat = PAT_BLANK;
            default:  pat = PAT_QUERY;
        endcase
    end

endmodule

// File: rtl/seg_disp_bank.sv
module seg_disp_bank
    import seg_disp_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_SLOTS-1:0][SEG_W-1:0]     seg_o
);

    localparam int MIN_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    initial begin
        if (IDX_W < MIN_IDX_W)
            $error("IDX_W too narrow for NUM_SLOTS");
    end

    logic [NUM_SLOTS-1:0] slot_we;
    disp_byte_t           slot_val [NUM_SLOTS];

    seg_wr_demux #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_demux (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .slot_we (slot_we)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        seg_slot_reg u_reg (
            .clk (clk),
            .rst (rst),
            .we  (slot_we[k]),
            .din (wr_data),
            .q   (slot_val[k])
        );

        seg_glyph_dec u_dec (
            .val (slot_val[k]),
            .pat (seg_o[k])
        );
    end

endmodule

// File: rtl/seg_disp_bank_chk.sv
module seg_disp_bank_chk
    import seg_disp_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [DATA_W-1:0]               wr_data,
    input logic [NUM_SLOTS-1:0][SEG_W-1:0] seg_o
);

    AST_RESET_BLANK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seg_o == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(seg_o)); // R4

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) >= NUM_SLOTS)) |=> $stable(seg_o)); // R5

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        AST_OTHER_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx != IDX_W'(k))) |=> $stable(seg_o[k])); // R3

        AST_HEX_LIT: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx == IDX_W'(k)) && (wr_data[7:4] == 4'h0))
            |=> (seg_o[k] != 7'h00 && seg_o[k] != 7'h53)); // R6

        AST_BLANK_CODE: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx == IDX_W'(k)) && (wr_data == 8'hFF))
            |=> (seg_o[k] == 7'h00)); // R7

        AST_QUERY_GLYPH: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx == IDX_W'(k)) && (wr_data[7:4] != 4'h0) && (wr_data != 8'hFF))
            |=> (seg_o[k] == 7'h53)); // R8
    end

endmodule

bind seg_disp_bank seg_disp_bank_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .seg_o   (seg_o)
);

// File: tb/sim_seg_disp_bank.sv
`timescale 1ns/1ps
module sim_seg_disp_bank;

    localparam int NS   = 4;
    localparam int IW   = 3;
    localparam int NVEC = 24;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   wr_en;
    logic [IW-1:0]          wr_idx;
    logic [7:0]             wr_data;
    logic [NS-1:0][6:0]     seg;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [6:0] model [NS];

    always #10 clk = ~clk;   // 50 MHz

    seg_disp_bank #(.NUM_SLOTS(NS), .IDX_W(IW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .seg_o   (seg)
    );

    // Vectors: index, data, expected glyph on that slot
    localparam logic [IW-1:0] V_IDX [NVEC] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd1, 3'd2, 3'd3,
        3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd1, 3'd2, 3'd3,
        3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd1, 3'd2, 3'd3};
    localparam logic [7:0] V_DAT [NVEC] = '{
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
        8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
        8'hFF, 8'h10, 8'hFE, 8'h80, 8'h7F, 8'hFF, 8'h1F, 8'hF0};
    localparam logic [6:0] V_EXP [NVEC] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71,
        7'h00, 7'h53, 7'h53, 7'h53, 7'h53, 7'h00, 7'h53, 7'h53};

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NS; k++)
            check(req, seg[k], model[k]);
    endtask

    task automatic write(input logic [IW-1:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = idx;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NS; k++) model[k] = 7'h00;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        do_reset();
        check_all("R1 reset blank");

        // Vector walk: written slot gets its glyph, others keep theirs (R2, R3, R6, R7, R8)
        for (int i = 0; i < NVEC; i++) begin
            write(V_IDX[i], V_DAT[i]);
            model[V_IDX[i]] = V_EXP[i];
            check_all("R2/R3/R6/R7/R8 vector");
        end

        // Known content before corner tests
        write(3'd0, 8'h01); model[0] = 7'h06;
        write(3'd1, 8'h02); model[1] = 7'h5B;
        write(3'd2, 8'h03); model[2] = 7'h4F;
        write(3'd3, 8'h04); model[3] = 7'h66;
        check_all("R2 setup");

        // R5: out-of-range indices leave every slot alone
        write(3'd4, 8'h08);
        check_all("R5 idx4");
        write(3'd7, 8'h00);
        check_all("R5 idx7");

        // R4: strobe low while index/data toggle
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            wr_idx  = IW'(c % NS);
            wr_data = 8'(c + 8'h0A);
        end
        @(negedge clk);
        check_all("R4 strobe low");

        // R9: back-to-back writes on the same slot
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_data = 8'h0C;
        @(negedge clk);
        check("R9 first write", seg[2], 7'h39);
        wr_data = 8'h0E;
        @(negedge clk);
        wr_en = 1'b0;
        model[2] = 7'h79;
        check_all("R9 last wins");

        // R1: reset in mid-run blanks everything again
        do_reset();
        check_all("R1 reset again");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule